// File: doc/BRIEF.md
# Partitioned CAM/RAM Word Array

This block is the storage and search core of a content-addressable memory. It holds a parameterised number of 64-bit entries. Each entry also carries a skip bit and an empty bit. A 3-bit partition code divides every entry into a compared (CAM) part and an associated-data (RAM) part, on 16-bit boundaries. The RAM part can sit at the low end or at the high end of the word. A comparand register is matched in parallel against the CAM part of every live entry, under an optional compare mask. The block reports the lowest-addressed match and the lowest-addressed empty entry at all times.

Entries are read and written directly, or data is moved between an entry and the comparand register. The target entry of every access comes from one of four sources: the address supplied with the operation, an internal address register, the next-free entry, or the highest-priority match. Writes and moves can be protected bit by bit by either of two mask registers. A bit set in the selected mask keeps its old value. One operation is accepted per cycle. Its effect is visible at the outputs after the next clock edge.

Top module: `cam_word_array`

## Requirements
- R1: A synchronous active-high reset leaves every entry empty and not skipped, with all data bits zero. It also clears the comparand, both masks, the address register and the compare mask select, and sets the partition code to 0 (all bits CAM). After reset full_flag=0, free_addr=0, match_flag=0 and rd_valid=0.
- R2: WRITE (op_code 6) stores op_data into the target entry and clears its empty and skip bits. op_msel selects the protection mask: 0 or 3 selects none, 1 selects mask A and 2 selects mask B. Bits set in the selected mask keep their old value.
- R3: An entry matches when its CAM bits equal the comparand on every bit not excluded by the compare mask. The compare mask is mask A or mask B, picked by the op_msel value latched by LD_CMP (op_code 2). match_flag and match_addr give the lowest-addressed matching entry, and they reflect the state left by the preceding clock edge.
- R4: An entry whose skip bit or empty bit is set never matches.
- R5: In the partition code, bits [1:0] give n, the number of 16-bit RAM segments. Bit 2 places them at the high end (1) or the low end (0). Codes 0 and 4 are all CAM. Code 1 makes bits 63:16 CAM and bits 15:0 RAM. Code 5 makes bits 47:0 CAM. RAM bits never affect matching. CFG (op_code 1) loads the code from op_data[2:0].
- R6: free_addr is the lowest-addressed empty entry. full_flag is 1 when no entry is empty, and free_addr is then 0.
- R7: op_src selects the target address: 0 selects op_addr, 1 the address register (loaded by LD_ADDR, op_code 5), 2 the next-free entry, and 3 the highest-priority match. An access whose source is 2 while full_flag=1, or 3 while match_flag=0, changes no entry and produces no read.
- R8: READ (op_code 7) presents the target entry on rd_data with rd_valid=1 one cycle later. rd_valid is 0 after any cycle without an accepted read.
- R9: MOV_E2C (op_code 8) loads the comparand from the target entry, and bits set in the selected mask keep the comparand's old value. MOV_C2E (op_code 9) writes the comparand into the target entry under the selected mask, and it clears the entry's empty and skip bits.
- R10: SET_EMPTY (op_code 10) sets the target entry's empty bit. SET_SKIP (op_code 11) sets its skip bit. LD_MASKA (3) and LD_MASKB (4) load the masks from op_data. Op_code 0 and unused codes do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| op_src | input | 2 | Target address source |
| op_msel | input | 2 | Mask select |
| op_addr | input | AW | Direct address |
| op_data | input | 64 | Operation data |
| rd_data | output | 64 | Read result |
| rd_valid | output | 1 | Read result valid |
| match_flag | output | 1 | Some live entry matches |
| match_addr | output | AW | Lowest matching entry |
| full_flag | output | 1 | No entry is empty |
| free_addr | output | AW | Lowest empty entry |

## Verification
Two functions can change in the same cycle. A write or move that lands on the next-free entry also changes the compare result, so the free address and the match address move at the same clock edge. The bench provokes this with moves of the comparand into an empty entry, and with skip and empty updates on the entry that currently matches. After that single operation it checks both outputs together. It also aims accesses at the match or free source while no match exists or the array is full, and it checks that no entry changes and that no read appears.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

    localparam int WORD_W = 64;
    localparam int SEG_W  = 16;
    localparam int NSEG   = WORD_W / SEG_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        OP_NOP       = 4'd0,
        OP_CFG       = 4'd1,
        OP_LD_CMP    = 4'd2,
        OP_LD_MASKA  = 4'd3,
        OP_LD_MASKB  = 4'd4,
        OP_LD_ADDR   = 4'd5,
        OP_WRITE     = 4'd6,
        OP_READ      = 4'd7,
        OP_MOV_E2C   = 4'd8,
        OP_MOV_C2E   = 4'd9,
        OP_SET_EMPTY = 4'd10,
        OP_SET_SKIP  = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        SRC_DIRECT = 2'd0,
        SRC_AREG   = 2'd1,
        SRC_FREE   = 2'd2,
        SRC_MATCH  = 2'd3
    } src_e;

    typedef struct packed {
        word_t      cmp;
        word_t      mska;
        word_t      mskb;
        logic [2:0] part;
        logic [1:0] cmsel;
    } ctl_t;

    // Which bits are compared, given a partition code.
    function automatic word_t cam_bits(input logic [2:0] code);
        word_t r;
        int    n;
        logic  ram;
        n = int'(code[1:0]);
        r = '0;
        for (int s = 0; s < NSEG; s++) begin
            if (n >= NSEG)
                ram = 1'b0;
            else if (code[2])
                ram = (s >= NSEG - n);
            else
                ram = (s < n);
            r[s*SEG_W +: SEG_W] = ram ? '0 : '1;
        end
        return r;
    endfunction

    function automatic word_t pick_mask(input logic [1:0] sel,
                                        input word_t ma, input word_t mb);
        case (sel)
            2'd1:    return ma;
            2'd2:    return mb;
            default: return '0;
        endcase
    endfunction

    // Bits set in keep retain old; others take nw.
    function automatic word_t merge(input word_t old, input word_t nw,
                                    input word_t keep);
        return (old & keep) | (nw & ~keep);
    endfunction

endpackage

// File: rtl/cwa_match_row.sv
module cwa_match_row
    import cwa_pkg::*;
(
    input  word_t entry,
    input  logic  skip,
    input  logic  empty,
    input  word_t comparand,
    input  word_t care,
    output logic  hit
);
    word_t diff;

    always_comb begin
        diff = (entry ^ comparand) & care;
        hit  = !skip && !empty && (diff == '0);
    end

    // R4: dead entries never report a hit
    always_comb begin
        if (skip || empty) begin
            p_dead_no_hit_r4: assert (!hit);
        end
    end

endmodule

// File: rtl/cwa_prio_enc.sv
module cwa_prio_enc #(
    parameter int N  = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [AW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = AW'(i);
            end
        end
    end

    logic [N-1:0] below;
    always_comb below = (N'(1) << idx) - N'(1);

    // R3/R6: reported index is the lowest requester
    p_lowest_first_r3: assert property (@(posedge clk) disable iff (rst)
        hit |-> (req[idx] && ((req & below) == '0)));

    p_none_means_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (req == '0 && idx == '0));

endmodule

// File: rtl/cwa_addr_sel.sv
module cwa_addr_sel
    import cwa_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic [1:0]    src,
    input  logic [AW-1:0] direct_addr,
    input  logic [AW-1:0] areg,
    input  logic [AW-1:0] free_addr,
    input  logic          full,
    input  logic [AW-1:0] match_addr,
    input  logic          match_hit,
    output logic [AW-1:0] eff_addr,
    output logic          ok
);
    always_comb begin
        eff_addr = direct_addr;
        ok       = 1'b1;
        case (src_e'(src))
            SRC_DIRECT: eff_addr = direct_addr;
            SRC_AREG:   eff_addr = areg;
            SRC_FREE: begin
                eff_addr = free_addr;
                ok       = !full;
            end
            SRC_MATCH: begin
                eff_addr = match_addr;
                ok       = match_hit;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cam_word_array.sv
module cam_word_array
    import cwa_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [1:0]    op_src,
    input  logic [1:0]    op_msel,
    input  logic [AW-1:0] op_addr,
    input  logic [63:0]   op_data,
    output logic [63:0]   rd_data,
    output logic          rd_valid,
    output logic          match_flag,
    output logic [AW-1:0] match_addr,
    output logic          full_flag,
    output logic [AW-1:0] free_addr
);
    word_t            mem [DEPTH];
    logic [DEPTH-1:0] empty_q;
    logic [DEPTH-1:0] skip_q;
    ctl_t             ctl_q;
    logic [AW-1:0]    areg_q;
    word_t            rd_data_q;
    logic             rd_valid_q;

    // ---- compare ----
    word_t            care;
    logic [DEPTH-1:0] hits;

    always_comb care = cam_bits(ctl_q.part) & ~pick_mask(ctl_q.cmsel, ctl_q.mska, ctl_q.mskb);

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        cwa_match_row u_row (
            .entry     (mem[g]),
            .skip      (skip_q[g]),
            .empty     (empty_q[g]),
            .comparand (ctl_q.cmp),
            .care      (care),
            .hit       (hits[g])
        );
    end

    logic          m_hit;
    logic [AW-1:0] m_idx;
    cwa_prio_enc #(.N(DEPTH), .AW(AW)) u_match_enc (
        .clk (clk), .rst (rst), .req (hits), .hit (m_hit), .idx (m_idx)
    );

    logic          f_hit;
    logic [AW-1:0] f_idx;
    cwa_prio_enc #(.N(DEPTH), .AW(AW)) u_free_enc (
        .clk (clk), .rst (rst), .req (empty_q), .hit (f_hit), .idx (f_idx)
    );

    // ---- address source ----
    logic [AW-1:0] eff_addr;
    logic          addr_ok;
    cwa_addr_sel #(.AW(AW)) u_asel (
        .src         (op_src),
        .direct_addr (op_addr),
        .areg        (areg_q),
        .free_addr   (f_idx),
        .full        (!f_hit),
        .match_addr  (m_idx),
        .match_hit   (m_hit),
        .eff_addr    (eff_addr),
        .ok          (addr_ok)
    );

    op_e   op;
    word_t keep;
    word_t cur;
    logic  in_range;
    always_comb begin
        op       = op_e'(op_code);
        keep     = pick_mask(op_msel, ctl_q.mska, ctl_q.mskb);
        in_range = (int'(eff_addr) < DEPTH);
        cur      = in_range ? mem[eff_addr] : '0;
    end

    logic acc;
    always_comb acc = op_valid && addr_ok && in_range;

    // ---- state ----
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            empty_q    <= '1;
            skip_q     <= '0;
            ctl_q      <= '0;
            areg_q     <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            if (op_valid) begin
                case (op)
                    OP_CFG:      ctl_q.part <= op_data[2:0];
                    OP_LD_CMP: begin
                        ctl_q.cmp   <= op_data;
                        ctl_q.cmsel <= op_msel;
                    end
                    OP_LD_MASKA: ctl_q.mska <= op_data;
                    OP_LD_MASKB: ctl_q.mskb <= op_data;
                    OP_LD_ADDR:  areg_q     <= op_addr;
                    OP_WRITE: if (acc) begin
                        mem[eff_addr]     <= merge(cur, op_data, keep);
                        empty_q[eff_addr] <= 1'b0;
                        skip_q[eff_addr]  <= 1'b0;
                    end
                    OP_READ: if (acc) begin
                        rd_data_q  <= cur;
                        rd_valid_q <= 1'b1;
                    end
                    OP_MOV_E2C: if (acc) begin
                        ctl_q.cmp <= merge(ctl_q.cmp, cur, keep);
                    end
                    OP_MOV_C2E: if (acc) begin
                        mem[eff_addr]     <= merge(cur, ctl_q.cmp, keep);
                        empty_q[eff_addr] <= 1'b0;
                        skip_q[eff_addr]  <= 1'b0;
                    end
                    OP_SET_EMPTY: if (acc) empty_q[eff_addr] <= 1'b1;
                    OP_SET_SKIP:  if (acc) skip_q[eff_addr]  <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data    = rd_data_q;
        rd_valid   = rd_valid_q;
        match_flag = m_hit;
        match_addr = m_idx;
        full_flag  = !f_hit;
        free_addr  = f_idx;
    end

    // ---- assertions ----
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: right after reset every entry is empty and nothing is live
    p_reset_clear_r1: assert property (@(posedge clk)
        rst_d |-> (empty_q == '1 && skip_q == '0 && !full_flag && !match_flag));

    // R8: read result follows an accepted read by one cycle
    p_read_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_READ && acc) |=> rd_valid);

    p_read_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && op == OP_READ) |=> !rd_valid);

    // R2: an accepted write makes the target entry live
    p_write_live_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_WRITE && acc) |=>
            (!empty_q[$past(eff_addr)] && !skip_q[$past(eff_addr)]));

    // R7: unavailable address source leaves validity bits alone
    p_blocked_src_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !addr_ok) |=> ($stable(empty_q) && $stable(skip_q) && !rd_valid));

    // R6: full only when nothing is empty
    p_full_free_r6: assert property (@(posedge clk) disable iff (rst)
        full_flag |-> (free_addr == '0 && $countones(empty_q) == 0));

endmodule

// File: tb/sim_cam_word_array.sv
`timescale 1ns/1ps
module sim_cam_word_array;

    localparam logic [3:0] C_NOP = 4'd0, C_CFG = 4'd1, C_LDCMP = 4'd2,
        C_LDMA = 4'd3, C_LDMB = 4'd4, C_LDADDR = 4'd5, C_WR = 4'd6,
        C_RD = 4'd7, C_E2C = 4'd8, C_C2E = 4'd9, C_SETE = 4'd10, C_SETS = 4'd11;

    localparam int K_RD = 0, K_RDV = 1, K_MF = 2, K_MA = 3, K_FULL = 4, K_FREE = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [1:0]  op_src = '0;
    logic [1:0]  op_msel = '0;
    logic [3:0]  op_addr = '0;
    logic [63:0] op_data = '0;
    logic [63:0] rd_data;
    logic        rd_valid;
    logic        match_flag;
    logic [3:0]  match_addr;
    logic        full_flag;
    logic [3:0]  free_addr;

    always #2 clk = ~clk;

    cam_word_array #(.DEPTH(16)) u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_src(op_src), .op_msel(op_msel), .op_addr(op_addr), .op_data(op_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .match_flag(match_flag),
        .match_addr(match_addr), .full_flag(full_flag), .free_addr(free_addr)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    int          kind_q[$];
    logic [63:0] val_q[$];
    string       req_q[$];

    task automatic expect_out(input int k, input logic [63:0] v, input string r);
        kind_q.push_back(k);
        val_q.push_back(v);
        req_q.push_back(r);
    endtask

    task automatic do_op(input logic [3:0] c, input logic [1:0] s,
                         input logic [3:0] a, input logic [1:0] m,
                         input logic [63:0] d);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_src = s; op_addr = a; op_msel = m; op_data = d;
        @(posedge clk);
        #1 op_valid = 1'b0;
    endtask

    task automatic idle();
        do_op(C_NOP, 2'd0, 4'd0, 2'd0, 64'd0);
    endtask

    // monitor: compare outputs with queued expectations
    int          mk;
    logic [63:0] mv;
    logic [63:0] act;
    string       mr;
    always @(negedge clk) begin
        while (kind_q.size() > 0) begin
            mk = kind_q.pop_front();
            mv = val_q.pop_front();
            mr = req_q.pop_front();
            case (mk)
                K_RD:    act = rd_data;
                K_RDV:   act = {63'd0, rd_valid};
                K_MF:    act = {63'd0, match_flag};
                K_MA:    act = {60'd0, match_addr};
                K_FULL:  act = {63'd0, full_flag};
                default: act = {60'd0, free_addr};
            endcase
            n_checks++;
            if (act !== mv) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", mr, mk, act, mv);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        idle();
        // R1 reset state
        expect_out(K_FULL, 0, "R1"); expect_out(K_FREE, 0, "R1");
        expect_out(K_MF, 0, "R1");   expect_out(K_RDV, 0, "R1");

        do_op(C_LDMA, 0, 0, 0, 64'h0000_0000_0000_FFFF);
        do_op(C_LDMB, 0, 0, 0, 64'hFFFF_0000_0000_0000);

        // direct write to 3, then next-free write lands on 0
        do_op(C_WR, 0, 4'd3, 0, 64'h1111_2222_3333_4444);
        expect_out(K_FREE, 0, "R6");
        do_op(C_WR, 2, 4'd9, 0, 64'hAAAA_BBBB_CCCC_DDDD);
        expect_out(K_FREE, 1, "R7");

        do_op(C_RD, 0, 4'd0, 0, 0);
        expect_out(K_RD, 64'hAAAA_BBBB_CCCC_DDDD, "R8");
        expect_out(K_RDV, 1, "R8");
        idle();
        expect_out(K_RDV, 0, "R8");

        // R2 masked write: mask A protects low 16 bits
        do_op(C_WR, 0, 4'd3, 1, 64'h5555_6666_7777_8888);
        do_op(C_LDADDR, 0, 4'd3, 0, 0);
        do_op(C_RD, 1, 4'd0, 0, 0);
        expect_out(K_RD, 64'h5555_6666_7777_4444, "R2");

        // R3 compare and lowest-address priority
        do_op(C_LDCMP, 0, 0, 0, 64'h5555_6666_7777_4444);
        expect_out(K_MF, 1, "R3"); expect_out(K_MA, 3, "R3");
        do_op(C_WR, 0, 4'd1, 0, 64'h5555_6666_7777_4444);
        expect_out(K_MA, 1, "R3");

        // R5 partition codes
        do_op(C_LDCMP, 0, 0, 0, 64'h5555_6666_7777_0000);
        expect_out(K_MF, 0, "R5");
        do_op(C_CFG, 0, 0, 0, 64'd1);
        expect_out(K_MF, 1, "R5"); expect_out(K_MA, 1, "R5");
        do_op(C_CFG, 0, 0, 0, 64'd4);
        expect_out(K_MF, 0, "R5");
        do_op(C_LDCMP, 0, 0, 0, 64'h0000_6666_7777_4444);
        expect_out(K_MF, 0, "R5");
        do_op(C_CFG, 0, 0, 0, 64'd5);
        expect_out(K_MF, 1, "R5"); expect_out(K_MA, 1, "R5");
        do_op(C_CFG, 0, 0, 0, 64'd0);
        expect_out(K_MF, 0, "R5");

        // R3 compare mask A excludes low 16 bits
        do_op(C_LDCMP, 0, 0, 1, 64'h5555_6666_7777_0000);
        expect_out(K_MF, 1, "R3"); expect_out(K_MA, 1, "R3");

        // R4 / R10 skip and empty
        do_op(C_SETS, 0, 4'd1, 0, 0);
        expect_out(K_MA, 3, "R4");
        do_op(C_SETE, 0, 4'd3, 0, 0);
        expect_out(K_MF, 0, "R4"); expect_out(K_FREE, 2, "R10");

        // R7 match source with no match: nothing happens
        do_op(C_WR, 3, 4'd0, 0, 64'h1234);
        expect_out(K_FREE, 2, "R7"); expect_out(K_MF, 0, "R7");
        do_op(C_RD, 3, 4'd0, 0, 0);
        expect_out(K_RDV, 0, "R7");

        // R9 comparand into entry 2: free and match move together
        do_op(C_C2E, 0, 4'd2, 0, 0);
        expect_out(K_FREE, 3, "R9"); expect_out(K_MF, 1, "R9"); expect_out(K_MA, 2, "R9");
        do_op(C_RD, 3, 4'd0, 0, 0);
        expect_out(K_RD, 64'h5555_6666_7777_0000, "R9");

        // R2 write clears skip on entry 1
        do_op(C_WR, 0, 4'd1, 0, 64'h5555_6666_7777_9999);
        expect_out(K_MA, 1, "R2");

        // R9 entry 0 into comparand, mask B keeps high 16
        do_op(C_E2C, 0, 4'd0, 2, 0);
        expect_out(K_MF, 0, "R9");
        do_op(C_C2E, 2, 4'd0, 0, 0);
        expect_out(K_MF, 1, "R9"); expect_out(K_MA, 3, "R9"); expect_out(K_FREE, 4, "R6");
        do_op(C_RD, 0, 4'd3, 0, 0);
        expect_out(K_RD, 64'h5555_BBBB_CCCC_DDDD, "R9");

        // R6 fill the rest through next-free
        for (int i = 0; i < 12; i++) begin
            do_op(C_WR, 2, 4'd0, 0, 64'h100 + 64'(i));
        end
        expect_out(K_FULL, 1, "R6"); expect_out(K_FREE, 0, "R6");
        do_op(C_RD, 0, 4'd15, 0, 0);
        expect_out(K_RD, 64'h10B, "R6");
        do_op(C_RD, 2, 4'd0, 0, 0);
        expect_out(K_RDV, 0, "R7");

        // R1 reset again
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        idle();
        expect_out(K_FULL, 0, "R1"); expect_out(K_FREE, 0, "R1"); expect_out(K_MF, 0, "R1");

        idle();
        idle();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule